// File: doc/BRIEF.md
# Flash Chip-Select Window Decoder

This block sits between a host bus and a serial flash engine. It takes host offsets that already lie inside a 256 MiB memory-mapped flash window and decides which flash device the access belongs to. Each chip-select owns one segment register. The register holds a first and a last 1 MiB unit, both measured from the window base rather than as system addresses. The decode is purely combinational: an offset presented on `addr_i` gives a one-hot chip-select, a hit flag and the byte offset inside the chosen segment in the same cycle.

Software programs the segments through a small register port. Each write takes effect on the next clock edge, and reads return data combinationally. A sticky status bit records any moment at which two live segments claimed the same megabyte. Software clears it by writing 1 to that bit.

Top module: `flash_cs_decoder`

## Requirements
- R1: After reset, chip-select 0 spans units 0x00 to 0x7F, so its register reads 0x07F00000. Every other chip-select register reads 0, and the overlap status reads 0.
- R2: A segment register holds the first unit in bits [11:4] and the last unit in bits [27:20]. All other bits read back as 0. Register index k (k below NUM_CS) selects chip-select k, and index 3 is the status register.
- R3: The first-unit field of chip-select 0 always reads 0. Writes to that field are ignored, while its last-unit field stays writable.
- R4: A segment whose two fields are both zero is disabled and matches no offset.
- R5: An offset whose bits [27:20] lie within [first, last] of an enabled segment raises `hit_o` and the matching one-hot bit of `cs_o`. Both bounds are inclusive.
- R6: On a hit, `seg_off_o` equals the offset minus first × 1 MiB.
- R7: When several segments match, the lowest-numbered chip-select wins.
- R8: A segment written with last below first reads back exactly as written but matches no offset.
- R9: When no segment matches, `hit_o`, `cs_o` and `seg_off_o` are all 0.
- R10: While two enabled, well-formed segments share any 1 MiB unit, the overlap flag (`overlap_o`, status bit 0) is set on the next clock edge and stays set.
- R11: Writing 1 to status bit 0 clears the flag on the next edge, but only if no overlap is present at that time. Otherwise the flag stays set.
- R12: The decode outputs follow `addr_i` and the segment registers within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index (0..NUM_CS-1 segments, 3 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_idx_i` |
| addr_i | input | 28 | Byte offset inside the flash window |
| hit_o | output | 1 | Offset falls in an enabled segment |
| cs_o | output | NUM_CS | One-hot chip-select |
| seg_off_o | output | 28 | Byte offset within the selected segment |
| overlap_o | output | 1 | Sticky overlap flag |

## Verification
The assertions assume that `addr_i` is already a window-relative offset. They also assume that the register port is written only on clock edges with stable data, so the segments change only at edges. They do not assume well-formed segments. Inverted, zero and single-unit segments are all legal inputs, and the onehot, miss and offset-bound properties must hold for them too. The stimulus writes registers only in the low clock phase and then sweeps all 256 megabyte units, with two low-bit patterns each, under every configuration. This keeps every offset inside the 28-bit window and covers each segment edge exactly.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;
  localparam int WIN_AW     = 28;
  localparam int UNIT_W     = 8;
  localparam int UNIT_LSB   = WIN_AW - UNIT_W;
  localparam int START_LSB  = UNIT_LSB - 16;
  localparam int END_LSB    = UNIT_LSB;
  localparam int REG_W      = 32;
  localparam int REG_AW     = 2;
  localparam int STATUS_IDX = 3;
  localparam logic [UNIT_W-1:0] CS0_RST_END = 8'h7F;

  typedef struct packed {
    logic [UNIT_W-1:0] end_u;
    logic [UNIT_W-1:0] start_u;
  } seg_t;

  // enabled (non-zero) and well-formed (end >= start)
  function automatic logic seg_valid(seg_t s);
    return ((s.start_u != '0) || (s.end_u != '0)) && (s.end_u >= s.start_u);
  endfunction
endpackage

// File: rtl/flash_seg_regs.sv
module flash_seg_regs
  import flash_dec_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [REG_AW-1:0]       idx_i,
  input  logic [REG_W-1:0]        wdata_i,
  output seg_t [NUM_CS-1:0]       seg_o
);
  logic [UNIT_W-1:0] start_q [NUM_CS];
  logic [UNIT_W-1:0] end_q   [NUM_CS];

  for (genvar k = 0; k < NUM_CS; k++) begin : g_seg
    localparam logic [UNIT_W-1:0] RST_END = (k == 0) ? CS0_RST_END : '0;
    logic sel;
    assign sel = we_i && (idx_i == REG_AW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  end_q[k] <= RST_END;
      else if (sel) end_q[k] <= wdata_i[END_LSB +: UNIT_W];
    end

    if (k == 0) begin : g_fixed_start
      assign start_q[k] = '0;  // read-only start for cs0
    end else begin : g_rw_start
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  start_q[k] <= '0;
        else if (sel) start_q[k] <= wdata_i[START_LSB +: UNIT_W];
      end
    end

    assign seg_o[k] = '{end_u: end_q[k], start_u: start_q[k]};
  end
endmodule

// File: rtl/flash_seg_match.sv
module flash_seg_match
  import flash_dec_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  seg_t [NUM_CS-1:0]   seg_i,
  input  logic [WIN_AW-1:0]   addr_i,
  output logic                hit_o,
  output logic [NUM_CS-1:0]   cs_o,
  output logic [WIN_AW-1:0]   off_o
);
  logic [UNIT_W-1:0] unit;
  logic [NUM_CS-1:0] match;

  assign unit = addr_i[UNIT_LSB +: UNIT_W];

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cmp
    assign match[k] = seg_valid(seg_i[k]) &&
                      (unit >= seg_i[k].start_u) && (unit <= seg_i[k].end_u);
  end

  // descending scan so the lowest index is assigned last and wins
  always_comb begin
    hit_o = 1'b0;
    cs_o  = '0;
    off_o = '0;
    for (int k = NUM_CS - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o = 1'b1;
        cs_o  = NUM_CS'(1) << k;
        off_o = addr_i - {seg_i[k].start_u, {UNIT_LSB{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/flash_overlap_det.sv
module flash_overlap_det
  import flash_dec_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seg_t [NUM_CS-1:0] seg_i,
  input  logic              clr_i,
  output logic              ovl_o
);
  localparam int NPAIR = NUM_CS * NUM_CS;

  logic [NPAIR-1:0] pair_ovl;
  logic             ovl_now;
  logic             ovl_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_i
    for (genvar j = 0; j < NUM_CS; j++) begin : g_j
      if (i < j) begin : g_pair
        assign pair_ovl[i*NUM_CS+j] = seg_valid(seg_i[i]) && seg_valid(seg_i[j]) &&
                                      (seg_i[i].start_u <= seg_i[j].end_u) &&
                                      (seg_i[j].start_u <= seg_i[i].end_u);
      end else begin : g_none
        assign pair_ovl[i*NUM_CS+j] = 1'b0;
      end
    end
  end

  assign ovl_now = |pair_ovl;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovl_q <= 1'b0;
    else if (ovl_now) ovl_q <= 1'b1;
    else if (clr_i)   ovl_q <= 1'b0;
  end

  assign ovl_o = ovl_q;

  AST_OVL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_now |=> ovl_q); // R10
  AST_OVL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_q && !clr_i) |=> ovl_q); // R11
endmodule

// File: rtl/flash_cs_decoder.sv
module flash_cs_decoder
  import flash_dec_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_idx_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [27:0]        addr_i,
  output logic               hit_o,
  output logic [NUM_CS-1:0]  cs_o,
  output logic [27:0]        seg_off_o,
  output logic               overlap_o
);
  seg_t [NUM_CS-1:0] seg;
  logic              ovl_clr;

  flash_seg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .seg_o   (seg)
  );

  flash_seg_match #(.NUM_CS(NUM_CS)) u_match (
    .seg_i  (seg),
    .addr_i (addr_i),
    .hit_o  (hit_o),
    .cs_o   (cs_o),
    .off_o  (seg_off_o)
  );

  assign ovl_clr = reg_we_i && (reg_idx_i == REG_AW'(STATUS_IDX)) && reg_wdata_i[0];

  flash_overlap_det #(.NUM_CS(NUM_CS)) u_ovl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seg_i  (seg),
    .clr_i  (ovl_clr),
    .ovl_o  (overlap_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (reg_idx_i == REG_AW'(k)) begin
        reg_rdata_o[END_LSB +: UNIT_W]   = seg[k].end_u;
        reg_rdata_o[START_LSB +: UNIT_W] = seg[k].start_u;
      end
    end
    if (reg_idx_i == REG_AW'(STATUS_IDX)) reg_rdata_o[0] = overlap_o;
  end

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R7
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (cs_o == '0 && seg_off_o == '0)); // R9
  AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (seg_off_o <= addr_i)); // R6
endmodule

// File: tb/flash_cs_decoder_test.sv
module flash_cs_decoder_test;
  localparam int NCS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [27:0] addr = '0;
  logic        hit;
  logic [NCS-1:0] cs;
  logic [27:0] off;
  logic        ovl;

  int vectors = 0;
  int fails = 0;

  logic [7:0] st_m [NCS];
  logic [7:0] en_m [NCS];

  always #4 clk = ~clk;

  flash_cs_decoder #(.NUM_CS(NCS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .addr_i(addr),
    .hit_o(hit), .cs_o(cs), .seg_off_o(off), .overlap_o(ovl)
  );

  function automatic logic [31:0] mk(logic [7:0] s, logic [7:0] e);
    return {4'h0, e, 8'h00, s, 4'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] i, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (i < NCS) begin
      en_m[i] = d[27:20];
      if (i != 0) st_m[i] = d[11:4];  // R3: cs0 start stays 0
    end
  endtask

  task automatic rd(string req, logic [1:0] i, logic [31:0] exp);
    @(negedge clk);
    idx = i;
    #1 chk(req, rdata, exp);
  endtask

  task automatic sweep(string tag);
    for (int u = 0; u < 256; u++) begin
      for (int p = 0; p < 2; p++) begin
        logic [19:0] lo;
        logic [27:0] a;
        logic        eh;
        logic [NCS-1:0] ecs;
        logic [27:0] eoff;
        lo = (p == 0) ? 20'h00000 : (20'hFFFFF ^ 20'(u * 977));
        a = {u[7:0], lo};
        eh = 1'b0; ecs = '0; eoff = '0;
        for (int k = 0; k < NCS; k++) begin
          if (!eh && (st_m[k] != 0 || en_m[k] != 0) && en_m[k] >= st_m[k] &&
              u[7:0] >= st_m[k] && u[7:0] <= en_m[k]) begin
            eh = 1'b1; ecs = NCS'(1) << k; eoff = a - {st_m[k], 20'h0};
          end
        end
        @(negedge clk);
        addr = a;
        #1;  // R12: same-cycle decode
        if (eh) begin
          chk({tag, " R5 hit"}, 32'(hit), 32'(eh));
          chk({tag, " R5 R7 cs"}, 32'(cs), 32'(ecs));
          chk({tag, " R6 off"}, 32'(off), 32'(eoff));
        end else begin
          chk({tag, " R9 hit"}, 32'(hit), 32'h0);
          chk({tag, " R9 cs"}, 32'(cs), 32'h0);
          chk({tag, " R9 off"}, 32'(off), 32'h0);
        end
      end
    end
  endtask

  task automatic run_all();
    st_m[0] = 8'h00; en_m[0] = 8'h7F;
    for (int k = 1; k < NCS; k++) begin st_m[k] = '0; en_m[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 cs0", 2'd0, 32'h07F0_0000);
    rd("R1 cs1", 2'd1, 32'h0);
    rd("R1 cs2", 2'd2, 32'h0);
    rd("R1 status", 2'd3, 32'h0);
    chk("R1 overlap_o", 32'(ovl), 32'h0);
    sweep("R1 R4");

    // R2 field placement, R3 read-only start of cs0
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R2 junk bits dropped", 2'd1, 32'h0FF0_0FF0);
    wr(2'd0, mk(8'h55, 8'h3F));
    rd("R3 cs0 start ignored", 2'd0, mk(8'h00, 8'h3F));
    wr(2'd1, mk(8'h40, 8'h9F));
    wr(2'd2, mk(8'hA0, 8'hFF));
    rd("R2 cs1", 2'd1, mk(8'h40, 8'h9F));
    rd("R2 cs2", 2'd2, mk(8'hA0, 8'hFF));
    sweep("tiled");
    @(negedge clk);
    chk("R10 no overlap when tiled", 32'(ovl), 32'h0);

    // R7 priority and R10 overlap
    wr(2'd1, mk(8'h30, 8'h50));
    @(negedge clk);
    chk("R10 overlap set", 32'(ovl), 32'h1);
    rd("R10 status bit", 2'd3, 32'h1);
    sweep("R7 overlap");
    wr(2'd3, 32'h1);
    @(negedge clk);
    chk("R11 clear blocked while overlapping", 32'(ovl), 32'h1);
    wr(2'd1, mk(8'h40, 8'h50));
    @(negedge clk);
    chk("R10 sticky after overlap gone", 32'(ovl), 32'h1);
    wr(2'd3, 32'h0);
    @(negedge clk);
    chk("R11 write 0 keeps flag", 32'(ovl), 32'h1);
    wr(2'd3, 32'h1);
    @(negedge clk);
    chk("R11 clear", 32'(ovl), 32'h0);

    // R8 inverted segment
    wr(2'd2, mk(8'hF0, 8'h20));
    rd("R8 stored as written", 2'd2, mk(8'hF0, 8'h20));
    @(negedge clk);
    chk("R8 inverted segment no overlap", 32'(ovl), 32'h0);
    sweep("R8");

    // R4 disabled segments, single-unit segment
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd2, mk(8'h10, 8'h10));
    rd("R4 cs0 zero", 2'd0, 32'h0);
    sweep("R4 single");
    wr(2'd1, mk(8'h01, 8'hFF));
    @(negedge clk);
    chk("R10 overlap with single unit", 32'(ovl), 32'h1);
    sweep("R7 nested");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule